// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates the interrupt requests of a signal-processing core. Eleven serviceable request slots (a powerdown request, three external active-low request pins, two host-port events, four serial-port events, two software interrupts and a timer) are captured, filtered through a per-slot enable mask, an in-service record and a global enable, and the highest-priority survivor is presented to the program sequencer as a valid flag plus a fixed vector address. Reset is the block's own reset input: it returns every register to its idle state and leaves the vector output at 0x0000.

The sequencer answers a presented vector with a one-cycle "take" strobe and ends each handler with a one-cycle "return" strobe. Software reaches four write-only register slots through a small write port: the enable mask, a control word (edge or level sensitivity per external pin, nesting or sequential servicing, and whether the two upper serial-port slots are fed by the external pins), a force/clear word for the latched requests, and the global enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `irq_valid` is high, `irq_vector` is the fixed address of the selected slot: powerdown 0x2C, IRQ2 pin 0x04, host write 0x08, host read 0x0C, serial 0 transmit 0x10, serial 0 receive 0x14, software 1 0x18, software 0 0x1C, serial 1 transmit or pin 1 0x20, serial 1 receive or pin 0 0x24, timer 0x28; while `irq_valid` is low the vector is 0x0000. `irq_take` is only given while `irq_valid` is high.
- R2: Among eligible slots the one with the smallest vector wins, except that powerdown beats every other slot.
- R3: A request is eligible only if its bit in the mask register (register select 0, bit n for the slot whose vector is 4·n, 1 = enabled) is set; powerdown ignores the mask.
- R4: In the cycle after any mask-register write, `irq_valid` is low.
- R5: Global enable (register select 3, bit 0) low blocks every slot, powerdown included, without changing the mask; setting it again restores servicing. It is 1 out of reset.
- R6: An external pin in edge mode (control bits [2:0] for pins 0, 1, 2, 1 = edge) latches a request on a high-to-low transition; the request stays pending after the pin returns high and is cleared when its vector is taken.
- R7: An external pin in level mode requests only while it is low; the request is not latched and disappears when the pin goes high.
- R8: A write to the force/clear register (select 2) sets the latched requests whose bits are 1 in data [10:0] and clears those whose bits are 1 in data [21:11], bit n/11+n belonging to the slot with vector 4·n (bit 0 powerdown); this is how software interrupts are raised and dropped.
- R9: With nesting on (control bit 3 = 1), taking a vector marks its slot in service; while marked, that slot and lower-priority slots are blocked, higher ones may preempt, and a return strobe releases the highest-priority in-service slot.
- R10: With nesting off, no vector is presented while any slot is in service.
- R11: After reset the mask, all latched requests and all in-service marks are clear, the control word is 0, `irq_valid` is low and `irq_vector` is 0x0000.
- R12: Control bit 4 selects the source of the slots at 0x20/0x24: 0 takes the serial-port 1 transmit/receive strobes, 1 takes pins 1/0 and then those strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 3 | External request pins, active low, bit k = pin k |
| pwd_req | input | 1 | Powerdown request strobe |
| dev_req | input | 7 | Peripheral strobes: host write, host read, ser0 tx, ser0 rx, ser1 tx, ser1 rx, timer (bits 0..6) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 mask, 1 control, 2 force/clear, 3 global enable |
| reg_wdata | input | 22 | Register write data |
| irq_take | input | 1 | Sequencer took the presented vector |
| irq_ret | input | 1 | Return from interrupt |
| irq_valid | output | 1 | A vector is presented |
| irq_vector | output | 14 | Vector address |

## Verification
Assertions watch, on every cycle, that the grant is at most one-hot, that a mask write or a global disable silences the next cycle, that a take in sequential mode silences the following cycle, that a return removes exactly one in-service mark and that latched requests survive until taken or cleared. Only the bench's scenarios show the exact vector map and priority order, the difference between edge and level pins, the effect of the source-select bit, and preemption order under nesting, since those depend on sequences of pin edges, writes and handshakes compared with an independent model.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   localparam int NUM_SLOT = 11;
   localparam int NUM_EXT  = 3;
   localparam int NUM_DEV  = 7;

   // slot index = priority rank (0 highest)
   localparam int SLOT_PWD  = 0;
   localparam int SLOT_IRQ2 = 1;
   localparam int SLOT_HWR  = 2;
   localparam int SLOT_HRD  = 3;
   localparam int SLOT_S0TX = 4;
   localparam int SLOT_S0RX = 5;
   localparam int SLOT_S1TX = 8;
   localparam int SLOT_S1RX = 9;
   localparam int SLOT_TMR  = 10;

   typedef enum logic [1:0] {
      SEL_MASK   = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_FORCE  = 2'd2,
      SEL_GLOBAL = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic                sp1_pins;
      logic                nest;
      logic [NUM_EXT-1:0]  edge_mode;
   } ctrl_t;
endpackage

// File: rtl/pvic_capture.sv
module pvic_capture
   import pvic_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_EXT-1:0]  irq_n,
   input  ctrl_t               ctrl,
   input  logic                pwd_req,
   input  logic [NUM_DEV-1:0]  dev_req,
   input  logic [NUM_SLOT-1:0] force_set,
   input  logic [NUM_SLOT-1:0] force_clr,
   input  logic [NUM_SLOT-1:0] take_clr,
   output logic [NUM_SLOT-1:0] req
);
   if (NUM_EXT != 3) begin : g_bad_ext
      $error("pvic_capture expects three external pins");
   end

   logic [NUM_EXT-1:0]  prev_n;
   logic [NUM_EXT-1:0]  edge_hit;
   logic [NUM_EXT-1:0]  low_lvl;
   logic [NUM_SLOT-1:0] pend_q;
   logic [NUM_SLOT-1:0] set_v;
   logic [NUM_SLOT-1:0] lvl_v;
   logic [NUM_SLOT-1:0] keep_v;

   for (genvar k = 0; k < NUM_EXT; k++) begin : g_pin
      assign edge_hit[k] = ctrl.edge_mode[k] & prev_n[k] & ~irq_n[k];
      assign low_lvl[k]  = ~ctrl.edge_mode[k] & ~irq_n[k];
   end

   always_comb begin
      set_v = '0;
      lvl_v = '0;
      set_v[SLOT_PWD]  = pwd_req;
      set_v[SLOT_IRQ2] = edge_hit[2];
      lvl_v[SLOT_IRQ2] = low_lvl[2];
      set_v[SLOT_HWR]  = dev_req[0];
      set_v[SLOT_HRD]  = dev_req[1];
      set_v[SLOT_S0TX] = dev_req[2];
      set_v[SLOT_S0RX] = dev_req[3];
      set_v[SLOT_S1TX] = ctrl.sp1_pins ? edge_hit[1] : dev_req[4];
      lvl_v[SLOT_S1TX] = ctrl.sp1_pins & low_lvl[1];
      set_v[SLOT_S1RX] = ctrl.sp1_pins ? edge_hit[0] : dev_req[5];
      lvl_v[SLOT_S1RX] = ctrl.sp1_pins & low_lvl[0];
      set_v[SLOT_TMR]  = dev_req[6];
   end

   assign keep_v = pend_q & ~force_clr & ~take_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_n <= '1;
         pend_q <= '0;
      end else begin
         prev_n <= irq_n;
         pend_q <= keep_v | set_v | force_set;
      end
   end

   assign req = pend_q | lvl_v;

   assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(keep_v)) == $past(keep_v)));
endmodule

// File: rtl/pvic_pick.sv
module pvic_pick #(
   parameter int N     = 11,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     cand,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = cand[i] & ~seen[i];
      assign seen[i+1] = seen[i] | cand[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = IDX_W'(i);
      end
   end

   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/pvic_service.sv
module pvic_service #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         nest,
   input  logic         take,
   input  logic [N-1:0] grant,
   input  logic         ret,
   output logic [N-1:0] allow
);
   logic [N-1:0] isr_q;
   logic [N-1:0] ret_bit;
   logic [N:0]   above;
   logic         busy;

   assign ret_bit  = isr_q & (~isr_q + N'(1));
   assign busy     = |isr_q;
   assign above[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_allow
      assign above[i+1] = above[i] | isr_q[i];
      assign allow[i]   = nest ? ~above[i+1] : ~busy;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q <= '0;
      end else begin
         isr_q <= (isr_q & ~(ret ? ret_bit : '0)) | (take ? grant : '0);
      end
   end

   assert_ret_drops_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && busy && !take) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import pvic_pkg::*;
#(
   parameter int VEC_W    = 14,
   parameter int VEC_STEP = 4,
   localparam int DATA_W  = 2 * NUM_SLOT,
   localparam int IDX_W   = $clog2(NUM_SLOT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] irq_n,
   input  logic               pwd_req,
   input  logic [NUM_DEV-1:0] dev_req,
   input  logic               reg_we,
   input  logic [1:0]         reg_sel,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               irq_take,
   input  logic               irq_ret,
   output logic               irq_valid,
   output logic [VEC_W-1:0]   irq_vector
);
   if (VEC_STEP < 1 || NUM_SLOT * VEC_STEP >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector width too small for the vector map");
   end

   localparam logic [VEC_W-1:0] PWD_VEC = VEC_W'(NUM_SLOT * VEC_STEP);

   logic [NUM_SLOT-1:0] mask_q;
   ctrl_t               ctrl_q;
   logic                gie_q;
   logic                blk_q;
   logic                wr_mask, wr_ctrl, wr_force, wr_glob;
   logic [NUM_SLOT-1:0] force_set, force_clr, take_clr;
   logic [NUM_SLOT-1:0] req, allow, elig, grant;
   logic [IDX_W-1:0]    idx;
   logic                any;

   assign wr_mask  = reg_we && (reg_sel == SEL_MASK);
   assign wr_ctrl  = reg_we && (reg_sel == SEL_CTRL);
   assign wr_force = reg_we && (reg_sel == SEL_FORCE);
   assign wr_glob  = reg_we && (reg_sel == SEL_GLOBAL);

   assign force_set = wr_force ? reg_wdata[NUM_SLOT-1:0] : '0;
   assign force_clr = wr_force ? reg_wdata[DATA_W-1:NUM_SLOT] : '0;
   assign take_clr  = irq_take ? grant : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         ctrl_q <= '0;
         gie_q  <= 1'b1;
         blk_q  <= 1'b0;
      end else begin
         blk_q <= wr_mask;
         if (wr_mask) mask_q <= reg_wdata[NUM_SLOT-1:0];
         if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
         if (wr_glob) gie_q  <= reg_wdata[0];
      end
   end

   pvic_capture u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_n     (irq_n),
      .ctrl      (ctrl_q),
      .pwd_req   (pwd_req),
      .dev_req   (dev_req),
      .force_set (force_set),
      .force_clr (force_clr),
      .take_clr  (take_clr),
      .req       (req)
   );

   pvic_service #(.N(NUM_SLOT)) u_service (
      .clk   (clk),
      .rst_n (rst_n),
      .nest  (ctrl_q.nest),
      .take  (irq_take),
      .grant (grant),
      .ret   (irq_ret),
      .allow (allow)
   );

   // powerdown slot bypasses the mask
   assign elig = req & (mask_q | NUM_SLOT'(1)) & allow;

   pvic_pick #(.N(NUM_SLOT)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (elig),
      .grant (grant),
      .idx   (idx),
      .any   (any)
   );

   assign irq_valid  = any & gie_q & ~blk_q;
   assign irq_vector = !irq_valid        ? '0 :
                       grant[SLOT_PWD]   ? PWD_VEC :
                       VEC_W'(VEC_STEP) * VEC_W'(idx);

   assert_take_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> irq_valid);

   assert_mask_write_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> !irq_valid);

   assert_global_off_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_glob && !reg_wdata[0]) |=> !irq_valid);

   assert_seq_no_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && !ctrl_q.nest && !wr_ctrl) |=> !irq_valid);
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  irq_n = 3'b111;
   logic        pwd_req = 1'b0;
   logic [6:0]  dev_req = '0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [21:0] reg_wdata = '0;
   logic        irq_take = 1'b0;
   logic        irq_ret = 1'b0;
   logic        irq_valid;
   logic [13:0] irq_vector;

   int total = 0;
   int bad = 0;

   // reference model state
   logic [10:0] m_pend = '0, m_mask = '0, m_isr = '0;
   logic [4:0]  m_ctl = '0;
   logic        m_gie = 1'b1, m_blk = 1'b0;
   logic [2:0]  m_prev = 3'b111;
   logic        want_take = 1'b0;

   always #5 clk = ~clk;

   irq_vector_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .pwd_req(pwd_req), .dev_req(dev_req),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .irq_take(irq_take), .irq_ret(irq_ret),
      .irq_valid(irq_valid), .irq_vector(irq_vector)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int pick_slot(input logic [10:0] req);
      int idx = -1;
      for (int i = 10; i >= 0; i--) begin
         logic ok;
         ok = req[i] && (i == 0 || m_mask[i]) &&
              (m_ctl[3] ? ((int'(m_isr) & ((2 << i) - 1)) == 0) : (m_isr == 0));
         if (ok) idx = i;
      end
      return idx;
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [21:0] data);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
   endtask

   // one cycle: inputs already driven at negedge
   task automatic step(input string tag);
      logic [10:0] lvl, setv, frc, clr, tk;
      logic [2:0]  fall;
      logic        e_valid;
      int          idx, e_vec;
      #1;
      lvl = '0;
      if (!m_ctl[2] && !irq_n[2]) lvl[1] = 1'b1;
      if (m_ctl[4] && !m_ctl[1] && !irq_n[1]) lvl[8] = 1'b1;
      if (m_ctl[4] && !m_ctl[0] && !irq_n[0]) lvl[9] = 1'b1;
      idx = pick_slot(m_pend | lvl);
      e_valid = m_gie && !m_blk && (idx >= 0);
      e_vec = !e_valid ? 0 : (idx == 0 ? 'h2C : idx * 4);
      check(tag, "valid", int'(irq_valid), int'(e_valid));
      check(tag, "vector", int'(irq_vector), e_vec);
      irq_take = want_take && e_valid;
      fall = m_prev & ~irq_n;
      setv = '0;
      setv[0] = pwd_req;
      setv[1] = m_ctl[2] & fall[2];
      setv[5:2] = dev_req[3:0];
      setv[8] = m_ctl[4] ? (m_ctl[1] & fall[1]) : dev_req[4];
      setv[9] = m_ctl[4] ? (m_ctl[0] & fall[0]) : dev_req[5];
      setv[10] = dev_req[6];
      frc = '0; clr = '0;
      tk = irq_take ? (11'd1 << idx) : '0;
      if (reg_we) begin
         case (reg_sel)
            2'd0: m_mask = reg_wdata[10:0];
            2'd1: m_ctl = reg_wdata[4:0];
            2'd2: begin frc = reg_wdata[10:0]; clr = reg_wdata[21:11]; end
            default: m_gie = reg_wdata[0];
         endcase
      end
      m_blk = reg_we && reg_sel == 2'd0;
      m_pend = (m_pend & ~clr & ~tk) | setv | frc;
      if (irq_ret) m_isr = m_isr & ~(m_isr & (~m_isr + 11'd1));
      m_isr = m_isr | tk;
      m_prev = irq_n;
      @(negedge clk);
      pwd_req = 1'b0; dev_req = '0; reg_we = 1'b0; irq_take = 1'b0;
      irq_ret = 1'b0; want_take = 1'b0;
   endtask

   initial begin
      #1_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      check("R11", "valid in reset", int'(irq_valid), 0);
      check("R11", "vector in reset", int'(irq_vector), 0);
      rst_n = 1'b1;
      step("R11");

      // R3: masked timer stays silent, powerdown ignores the mask
      dev_req[6] = 1'b1; step("R3");
      step("R3");
      pwd_req = 1'b1; step("R3");
      want_take = 1'b1; step("R3");
      step("R10");
      irq_ret = 1'b1; step("R3");

      // R4: blocking cycle after a mask write
      wr(2'd0, 22'h7FF); step("R4");
      step("R4");
      step("R4");
      want_take = 1'b1; step("R4");
      irq_ret = 1'b1; step("R4");

      // R2: all peripheral sources at once, drained in priority order
      dev_req = 7'h7F; wr(2'd2, 22'h0C0); step("R2");
      for (int i = 0; i < 9; i++) begin
         want_take = 1'b1; step("R2");
         irq_ret = 1'b1; step("R2");
      end

      // R5: global disable blocks powerdown, mask survives
      wr(2'd3, 22'h0); step("R5");
      pwd_req = 1'b1; dev_req[1] = 1'b1; step("R5");
      step("R5");
      wr(2'd3, 22'h1); step("R5");
      want_take = 1'b1; step("R5");
      irq_ret = 1'b1; step("R5");
      want_take = 1'b1; step("R5");
      irq_ret = 1'b1; step("R5");

      // R7: level pin, not latched
      irq_n[2] = 1'b0; step("R7");
      step("R7");
      irq_n[2] = 1'b1; step("R7");

      // R6 / R12: edge pins feeding the serial-port 1 slots
      wr(2'd1, 22'h17); step("R6");
      irq_n[0] = 1'b0; step("R6");
      irq_n[0] = 1'b1; step("R6");
      step("R6");
      want_take = 1'b1; step("R6");
      irq_ret = 1'b1; step("R6");
      step("R6");
      dev_req[5:4] = 2'b11; step("R12");
      step("R12");
      irq_n[1] = 1'b0; step("R12");
      step("R12");
      want_take = 1'b1; irq_n[1] = 1'b1; step("R12");
      irq_ret = 1'b1; step("R12");
      wr(2'd1, 22'h00); step("R12");
      dev_req[5] = 1'b1; step("R12");
      want_take = 1'b1; step("R12");
      irq_ret = 1'b1; step("R12");

      // R8: software interrupt raised and dropped through force/clear
      wr(2'd2, 22'h080); step("R8");
      step("R8");
      wr(2'd2, 22'h1 << 18); step("R8");
      step("R8");

      // R9: nesting, preemption and return order
      wr(2'd1, 22'h08); step("R9");
      dev_req[6] = 1'b1; step("R9");
      want_take = 1'b1; step("R9");
      dev_req[0] = 1'b1; step("R9");
      want_take = 1'b1; step("R9");
      dev_req[2] = 1'b1; step("R9");
      step("R9");
      irq_ret = 1'b1; step("R9");
      want_take = 1'b1; step("R9");
      irq_ret = 1'b1; step("R9");
      irq_ret = 1'b1; step("R9");
      step("R9");

      // R10: sequential mode holds a higher request back
      wr(2'd1, 22'h00); step("R10");
      dev_req[6] = 1'b1; step("R10");
      want_take = 1'b1; step("R10");
      dev_req[0] = 1'b1; step("R10");
      step("R10");
      irq_ret = 1'b1; step("R10");
      want_take = 1'b1; step("R10");
      irq_ret = 1'b1; step("R10");

      // R1: constrained random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 100);
         dev_req = ($urandom % 4 == 0) ? 7'($urandom) : '0;
         pwd_req = ($urandom % 40 == 0);
         if ($urandom % 6 == 0) irq_n = 3'($urandom);
         if (r < 3) wr(2'd0, 22'($urandom));
         else if (r < 5) wr(2'd1, 22'($urandom % 32));
         else if (r < 8) wr(2'd2, 22'($urandom));
         else if (r < 9) wr(2'd3, 22'($urandom % 4 != 0));
         want_take = ($urandom % 2 == 0);
         irq_ret = ($urandom % 3 == 0);
         step("R1");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule